// File: doc/BRIEF.md
# Non-Posted Outstanding Request Limiter

This block sits between a user-side request source and a link-side transmitter and keeps count of how many non-posted requests are still waiting for completion. Every request issued through the valid/ready handshake adds one to the count. Every retire strobe takes one away. A retire marks the end of a request's life: its last completion arrived, it timed out, or it was terminated. Once the count reaches the effective limit, the ready output drops and no more requests are granted. This keeps the receive buffer for split completions from overflowing.

The limit is held in an internal 10-bit register. It is written by a load strobe and resets to 128, which matches a completion store sized for 128 split completions. Programmed values below 8 are reserved. Such a value raises an error flag and the block uses 8 instead. Values above the hardware ceiling of 256 outstanding requests are clamped to 256. A retire that arrives while nothing is outstanding is dropped and reported on a one-cycle error pulse.

Top module: `nprq_limiter`

## Requirements
- R1: After reset, outCount is 0, the limit register holds 128, reqReady is 1, limitErr is 0 and retireErr is 0.
- R2: A cycle with reqValid=1 and reqReady=1 and no retireStb increases outCount by one at the next clock edge.
- R3: A cycle with retireStb=1, no issue and outCount>0 decreases outCount by one at the next clock edge.
- R4: With outCount>0, an issue and a retire in the same cycle leave outCount unchanged.
- R5: reqReady is 1 exactly when outCount is below the effective limit. With the reset limit, outCount stops at 128.
- R6: cfgLoad=1 writes cfgLimit into the limit register at the next clock edge. reqReady reflects the new limit from that edge on.
- R7: A stored limit of 0 to 7 drives limitErr=1 and gives an effective limit of 8. A stored limit of 8 or more drives limitErr=0.
- R8: A stored limit above 256 gives an effective limit of 256 and does not raise limitErr.
- R9: When the limit is lowered below the current count, no grants are given. Retires drain the count, and grants resume only once outCount is below the new limit.
- R10: A retireStb while outCount is 0 leaves the count at 0, or at 1 if an issue happens in the same cycle. It also drives retireErr=1 for exactly the following cycle.
- R11: outCount never exceeds 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | User side offers a non-posted request |
| reqReady | output | 1 | Request is accepted this cycle when reqValid is also high |
| retireStb | input | 1 | One outstanding request has finished (completion, timeout or termination) |
| cfgLoad | input | 1 | Write strobe for the limit register |
| cfgLimit | input | 10 | Value written into the limit register |
| outCount | output | 9 | Number of requests currently outstanding |
| limitErr | output | 1 | Stored limit is in the reserved range below 8 |
| retireErr | output | 1 | One-cycle pulse after a retire arrived with nothing outstanding |

## Verification
The properties assume retireStb is a single-cycle strobe per finished request. They also assume that request acceptance depends only on reqValid and reqReady in the same cycle, so the source never treats a request as issued while reqReady is low. The bench drives reqValid, retireStb and cfgLoad only through per-cycle tasks. Each input is set just after a falling edge and cleared after one cycle. The bench issues a retire at zero count only on purpose, to exercise the underflow pulse. Limit changes are applied on their own cycles, so each property sees one cause per edge, apart from the deliberate issue-and-retire overlap.

// File: rtl/nprq_pkg.sv
`timescale 1ns/1ps
package nprq_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic incr;      // a request was granted this cycle
    logic decr;      // a valid retire this cycle
    logic underflow; // retire with nothing outstanding
  } nprqStrobe_t;
endpackage

// File: rtl/nprq_dp.sv
`timescale 1ns/1ps
module nprq_dp
  import nprq_pkg::*;
#(
  parameter int LIMIT_W   = 10,
  parameter int CNT_MAX   = 256,
  parameter int LIMIT_MIN = 8,
  parameter int LIMIT_RST = 128,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLoad,
  input  logic [LIMIT_W-1:0] cfgLimit,
  input  nprqStrobe_t        strobes,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   effLimit,
  output logic               limitErr,
  output logic               retireErr
);
  localparam logic [LIMIT_W-1:0] MIN_L   = LIMIT_W'(LIMIT_MIN);
  localparam logic [LIMIT_W-1:0] MAX_L   = LIMIT_W'(CNT_MAX);
  localparam logic [LIMIT_W-1:0] RST_L   = LIMIT_W'(LIMIT_RST);
  localparam logic [CNT_W-1:0]   MIN_C   = CNT_W'(LIMIT_MIN);
  localparam logic [CNT_W-1:0]   MAX_C   = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0]   ONE_C   = CNT_W'(1);

  logic [LIMIT_W-1:0] limitReg;

  // Programmed limit register
  always_ff @(posedge clk) begin
    if (!rstN)        limitReg <= RST_L;
    else if (cfgLoad) limitReg <= cfgLimit;
  end

  // Effective limit: reserved values lifted to the floor, large values capped
  always_comb begin
    limitErr = (limitReg < MIN_L);
    if (limitReg < MIN_L)      effLimit = MIN_C;
    else if (limitReg > MAX_L) effLimit = MAX_C;
    else                       effLimit = limitReg[CNT_W-1:0];
  end

  // Outstanding counter and underflow pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      retireErr <= 1'b0;
    end else begin
      retireErr <= strobes.underflow;
      if (strobes.incr && !strobes.decr)      count <= count + ONE_C;
      else if (strobes.decr && !strobes.incr) count <= count - ONE_C;
    end
  end
endmodule

// File: rtl/nprq_ctrl.sv
`timescale 1ns/1ps
module nprq_ctrl
  import nprq_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             reqValid,
  input  logic             retireStb,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] effLimit,
  output logic             reqReady,
  output nprqStrobe_t      strobes
);
  logic isEmpty;

  always_comb begin
    isEmpty           = (count == '0);
    reqReady          = (count < effLimit);
    strobes.incr      = reqValid && reqReady;
    strobes.decr      = retireStb && !isEmpty;
    strobes.underflow = retireStb && isEmpty;
  end
endmodule

// File: rtl/nprq_limiter.sv
`timescale 1ns/1ps
module nprq_limiter
  import nprq_pkg::*;
#(
  parameter int LIMIT_W   = 10,
  parameter int CNT_MAX   = 256,
  parameter int LIMIT_MIN = 8,
  parameter int LIMIT_RST = 128,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               retireStb,
  input  logic               cfgLoad,
  input  logic [LIMIT_W-1:0] cfgLimit,
  output logic [CNT_W-1:0]   outCount,
  output logic               limitErr,
  output logic               retireErr
);
  nprqStrobe_t      strobes;
  logic [CNT_W-1:0] effLimit;

  nprq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .reqValid (reqValid),
    .retireStb(retireStb),
    .count    (outCount),
    .effLimit (effLimit),
    .reqReady (reqReady),
    .strobes  (strobes)
  );

  nprq_dp #(
    .LIMIT_W  (LIMIT_W),
    .CNT_MAX  (CNT_MAX),
    .LIMIT_MIN(LIMIT_MIN),
    .LIMIT_RST(LIMIT_RST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgLoad  (cfgLoad),
    .cfgLimit (cfgLimit),
    .strobes  (strobes),
    .count    (outCount),
    .effLimit (effLimit),
    .limitErr (limitErr),
    .retireErr(retireErr)
  );
endmodule

// File: rtl/nprq_limiter_chk.sv
`timescale 1ns/1ps
module nprq_limiter_chk #(
  parameter int LIMIT_W   = 10,
  parameter int CNT_MAX   = 256,
  parameter int LIMIT_MIN = 8,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               retireStb,
  input logic               cfgLoad,
  input logic [LIMIT_W-1:0] cfgLimit,
  input logic [CNT_W-1:0]   outCount,
  input logic               limitErr,
  input logic               retireErr
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(LIMIT_MIN);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  // R2
  issue_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !retireStb) |=> outCount == $past(outCount) + ONE_C);

  // R3
  retire_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retireStb && !(reqValid && reqReady) && outCount != '0) |=> outCount == $past(outCount) - ONE_C);

  // R4
  paired_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && retireStb && outCount != '0) |=> $stable(outCount));

  // R7
  floor_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (limitErr && outCount >= MIN_C) |-> !reqReady);

  // R10
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retireStb && outCount == '0) |=> retireErr);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    outCount <= MAX_C);

  // R11
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> outCount < MAX_C);

  // R6
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && cfgLimit >= LIMIT_W'(LIMIT_MIN)) |=> !limitErr);
endmodule

bind nprq_limiter nprq_limiter_chk #(
  .LIMIT_W  (LIMIT_W),
  .CNT_MAX  (CNT_MAX),
  .LIMIT_MIN(LIMIT_MIN)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .retireStb(retireStb),
  .cfgLoad  (cfgLoad),
  .cfgLimit (cfgLimit),
  .outCount (outCount),
  .limitErr (limitErr),
  .retireErr(retireErr)
);

// File: tb/test_nprq_limiter.sv
`timescale 1ns/1ps
module test_nprq_limiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       retireStb = 1'b0;
  logic       cfgLoad = 1'b0;
  logic [9:0] cfgLimit = '0;
  logic       reqReady;
  logic [8:0] outCount;
  logic       limitErr;
  logic       retireErr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  nprq_limiter i_nprq_limiter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .retireStb(retireStb), .cfgLoad(cfgLoad), .cfgLimit(cfgLimit),
    .outCount(outCount), .limitErr(limitErr), .retireErr(retireErr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus, starting and ending at a falling edge
  task automatic cyc(input bit v, input bit r);
    reqValid = v; retireStb = r;
    @(negedge clk);
    reqValid = 1'b0; retireStb = 1'b0;
  endtask

  task automatic loadLimit(input int val);
    cfgLoad = 1'b1; cfgLimit = 10'(val);
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic drain();
    while (outCount != 0) cyc(1'b0, 1'b1);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  task automatic testReset();
    chk("R1", "count", outCount, 0);
    chk("R1", "ready", reqReady, 1);
    chk("R1", "limitErr", limitErr, 0);
    chk("R1", "retireErr", retireErr, 0);
  endtask

  task automatic testStep();
    cyc(1'b1, 1'b0);
    chk("R2", "count after issue", outCount, 1);
    cyc(1'b1, 1'b0);
    chk("R2", "count after second issue", outCount, 2);
    cyc(1'b0, 1'b1);
    chk("R3", "count after retire", outCount, 1);
    cyc(1'b1, 1'b1);
    chk("R4", "count after paired", outCount, 1);
    cyc(1'b0, 1'b1);
    chk("R3", "count back to zero", outCount, 0);
  endtask

  task automatic testDefaultLimit();
    fill(130);
    chk("R5", "count at default limit", outCount, 128);
    chk("R1", "ready low at 128", reqReady, 0);
    cyc(1'b0, 1'b1);
    chk("R5", "ready after one retire", reqReady, 1);
    cyc(1'b1, 1'b0);
    chk("R5", "refill to 128", outCount, 128);
  endtask

  task automatic testLowerLimit();
    loadLimit(100);
    chk("R6", "ready low after load", reqReady, 0);
    for (int i = 0; i < 28; i++) cyc(1'b1, 1'b1);
    chk("R9", "drain with no grant", outCount, 100);
    chk("R9", "still blocked at limit", reqReady, 0);
    cyc(1'b0, 1'b1);
    chk("R9", "ready below new limit", reqReady, 1);
    fill(5);
    chk("R9", "stops at new limit", outCount, 100);
    drain();
  endtask

  task automatic testReserved();
    loadLimit(3);
    chk("R7", "limitErr for 3", limitErr, 1);
    fill(20);
    chk("R7", "floor of 8", outCount, 8);
    chk("R7", "ready at floor", reqReady, 0);
    loadLimit(0);
    chk("R7", "limitErr for 0", limitErr, 1);
    loadLimit(8);
    chk("R7", "limitErr clear at 8", limitErr, 0);
    chk("R7", "ready at 8 of 8", reqReady, 0);
    loadLimit(9);
    chk("R6", "ready after raise", reqReady, 1);
    drain();
  endtask

  task automatic testClamp();
    loadLimit(1023);
    chk("R8", "no limitErr for 1023", limitErr, 0);
    fill(300);
    chk("R8", "clamped at 256", outCount, 256);
    chk("R11", "ready low at ceiling", reqReady, 0);
    loadLimit(257);
    chk("R8", "257 still capped", outCount, 256);
    cyc(1'b0, 1'b1);
    chk("R8", "ready under cap", reqReady, 1);
    drain();
  endtask

  task automatic testUnderflow();
    cyc(1'b0, 1'b1);
    chk("R10", "count stays zero", outCount, 0);
    chk("R10", "retireErr pulse", retireErr, 1);
    cyc(1'b0, 1'b0);
    chk("R10", "retireErr one cycle", retireErr, 0);
    cyc(1'b1, 1'b1);
    chk("R10", "issue with stray retire", outCount, 1);
    chk("R10", "retireErr with issue", retireErr, 1);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStep();
    testDefaultLimit();
    testLowerLimit();
    testReserved();
    testClamp();
    testUnderflow();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule